// File: doc/BRIEF.md
# Serial Word Receive FIFO

This block holds 32-bit words that a serial-bus receiver has already checked and passed on, and gives them back to a host processor in arrival order. A word enters when the receiver pulses a write strobe with the word on the data input. The host asks for data with one of two decoded commands. One takes a single word. The other starts a drain that returns one word per cycle until the store is empty. Each returned word appears on a registered output together with a one-cycle valid pulse.

Four status outputs describe how full the store is. A data-ready flop sets when a word is accepted and clears when the last word leaves. The empty bit is the complement of that flop, so it is high only when nothing is held. A half-full bit rises at 16 words and a full bit rises at 32. When the store is full and a new word arrives with no pop in the same cycle, the newest slot is rewritten. Nothing is dropped and nothing stalls, and older entries keep their values.

Control is a two-state machine:
- **IDLE** is the state after reset and the state that accepts host commands.
- **DRAIN** pops a word every cycle.

There are four named transitions:
- **IDLE→DRAIN (start_drain)**: a drain command arrives and at least one word will still be held after this cycle's pop.
- **IDLE→IDLE (hold)**: any other case, including a drain command that empties the store in one pop.
- **DRAIN→DRAIN (continue)**: words remain after this cycle's pop.
- **DRAIN→IDLE (drain_done)**: the pop in this cycle leaves the store empty.

Top module: `rx_word_fifo`

## Requirements
- R1: A synchronous reset empties the store. After reset `stat_empty`=1 and `data_ready`, `stat_half`, `stat_full` and `rd_valid` are all 0.
- R2: In the cycle after `wr_stb` is sampled high, `data_ready`=1 and `stat_empty`=0.
- R3: Words come out in the order they were accepted, with all 32 bits unchanged. The store holds up to 32 words.
- R4: `stat_half` is 1 exactly when 16 or more words are held.
- R5: `stat_full` is 1 exactly when 32 words are held.
- R6: A write that arrives while 32 words are held and no pop happens in that cycle replaces the most recently written entry. The other 31 entries keep their values and `stat_full` stays 1.
- R7: In IDLE, `rd_one` on a non-empty store gives `rd_valid`=1 on the next cycle, with the oldest word on `rd_word`. Words held drop by one. In any cycle with no returned word, `rd_word` is zero.
- R8: In IDLE, `rd_all` on a non-empty store returns one word per consecutive cycle, in order, until the store is empty, then returns to IDLE. While draining, `rd_one` and `rd_all` have no effect. Words written during a drain are also returned by that drain.
- R9: In IDLE, `rd_one` or `rd_all` on an empty store gives one `rd_valid` pulse with `rd_word`=0. Occupancy is unchanged and no drain starts.
- R10: `stat_empty` stays 0 while any word is held. In the cycle after the last word is popped, `stat_empty` returns to 1 and `data_ready` to 0.
- R11: A write and a pop in the same cycle leave the number of words held unchanged. This includes a full store, where the pop takes the oldest word and the new word is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Accept `wr_word` as a valid received word |
| wr_word | input | 32 | Received word |
| rd_one | input | 1 | Host command: pop one word |
| rd_all | input | 1 | Host command: pop until empty |
| rd_valid | output | 1 | A read response is on `rd_word` this cycle |
| rd_word | output | 32 | Returned word, zero when none |
| data_ready | output | 1 | At least one word is held |
| stat_empty | output | 1 | High when no word is held (inverse of `data_ready`) |
| stat_half | output | 1 | 16 or more words held |
| stat_full | output | 1 | 32 words held |

## Verification
The bench drives the store to exactly 32 words and keeps writing, so a design that dropped the word, wrapped over the oldest entry or let the count pass 32 would return the wrong final word during the drain that follows. It issues `rd_one` pulses in the middle of a drain, which a design that obeyed them would show as a skipped word or a stretched stream. It also reads from an empty store, where a broken pointer guard would return stale data and drift the occupancy. Write-and-pop collisions at full and at partial occupancy catch a counter that moves when it should hold. The 15/16 and 31/32 boundaries are crossed repeatedly under random traffic.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [0:0] {
        RXF_IDLE  = 1'b0,
        RXF_DRAIN = 1'b1
    } rxf_state_e;
endpackage

// File: rtl/rxf_store.sv
// Word storage: one write port, one registered read port.
// The read register shows zero in any cycle without a read.
module rxf_store #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/rxf_track.sv
// Pointer and occupancy tracking, including the rewrite of the newest slot
// when a word arrives at a full store.
module rxf_track #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          has_data,
    output logic          next_zero,
    output logic          data_ready,
    output logic          stat_half,
    output logic          stat_full
);
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count, count_d;
    logic          is_full, append, rewrite;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
    endfunction

    always_comb begin
        is_full  = (count == CW'(DEPTH));
        has_data = (count != '0);
        append   = push && (!is_full || pop);
        rewrite  = push && is_full && !pop;
        count_d  = count + CW'(append) - CW'(pop);
        next_zero = (count_d == '0);
        wr_en    = push;
        wr_addr  = rewrite ? ptr_dec(wr_ptr) : wr_ptr;
        rd_addr  = rd_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            count      <= '0;
            data_ready <= 1'b0;
            stat_half  <= 1'b0;
            stat_full  <= 1'b0;
        end else begin
            if (append) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            count      <= count_d;
            data_ready <= (count_d != '0);
            stat_half  <= (count_d >= CW'(HALF));
            stat_full  <= (count_d == CW'(DEPTH));
        end
    end
endmodule

// File: rtl/rxf_ctrl.sv
// Read control: IDLE takes host commands, DRAIN pops every cycle until empty.
module rxf_ctrl
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_one,
    input  logic rd_all,
    input  logic has_data,
    input  logic next_zero,
    output logic pop,
    output logic draining,
    output logic rd_valid
);
    rxf_state_e state, state_d;
    logic       fire;

    always_comb begin
        state_d = state;
        pop     = 1'b0;
        fire    = 1'b0;
        unique case (state)
            RXF_IDLE: begin
                if (rd_all) begin
                    fire = 1'b1;
                    pop  = has_data;
                    if (has_data && !next_zero) begin
                        state_d = RXF_DRAIN;       // start_drain
                    end
                end else if (rd_one) begin
                    fire = 1'b1;
                    pop  = has_data;
                end
            end
            RXF_DRAIN: begin
                fire = has_data;
                pop  = has_data;
                if (next_zero) begin
                    state_d = RXF_IDLE;            // drain_done
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RXF_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= fire;
        end
    end

    assign draining = (state == RXF_DRAIN);
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_word,
    input  logic         rd_one,
    input  logic         rd_all,
    output logic         rd_valid,
    output logic [W-1:0] rd_word,
    output logic         data_ready,
    output logic         stat_empty,
    output logic         stat_half,
    output logic         stat_full
);
    logic          pop, draining, has_data, next_zero, wr_en;
    logic [AW-1:0] wr_addr, rd_addr;

    rxf_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rd_one    (rd_one),
        .rd_all    (rd_all),
        .has_data  (has_data),
        .next_zero (next_zero),
        .pop       (pop),
        .draining  (draining),
        .rd_valid  (rd_valid)
    );

    rxf_track #(.DEPTH(DEPTH)) u_track (
        .clk        (clk),
        .rst        (rst),
        .push       (wr_stb),
        .pop        (pop),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .has_data   (has_data),
        .next_zero  (next_zero),
        .data_ready (data_ready),
        .stat_half  (stat_half),
        .stat_full  (stat_full)
    );

    rxf_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_word),
        .re    (pop),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    assign stat_empty = ~data_ready;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_stb,
    input logic         rd_one,
    input logic         rd_all,
    input logic         rd_valid,
    input logic [W-1:0] rd_word,
    input logic         data_ready,
    input logic         stat_empty,
    input logic         stat_half,
    input logic         stat_full,
    input logic         draining
);
    assert_ready_after_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (data_ready && !stat_empty));

    assert_full_implies_half_R4: assert property (@(posedge clk) disable iff (rst)
        stat_full |-> stat_half);

    assert_full_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_full && wr_stb && !rd_one && !rd_all && !draining) |=> stat_full);

    assert_no_cmd_no_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (!rd_one && !rd_all && !draining) |=> (!rd_valid && rd_word == '0));

    assert_drain_stream_R8: assert property (@(posedge clk) disable iff (rst)
        (draining && !stat_empty) |=> rd_valid);

    assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_empty && rd_one && !draining) |=> (rd_valid && rd_word == '0));

    assert_empty_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (stat_empty && !wr_stb) |=> stat_empty);
endmodule

bind rx_word_fifo rxf_chk #(.W(W)) u_chk (.*);

// File: tb/rx_word_fifo_tb.sv
`timescale 1ns/1ps
module rx_word_fifo_tb;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [31:0] wr_word = '0;
    logic        rd_one = 1'b0;
    logic        rd_all = 1'b0;
    logic        rd_valid, data_ready, stat_empty, stat_half, stat_full;
    logic [31:0] rd_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] q[$];
    bit          m_drain = 0;
    logic        e_valid;
    logic [31:0] e_word;

    always #4 clk = ~clk;

    rx_word_fifo u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_word(wr_word),
        .rd_one(rd_one), .rd_all(rd_all), .rd_valid(rd_valid), .rd_word(rd_word),
        .data_ready(data_ready), .stat_empty(stat_empty),
        .stat_half(stat_half), .stat_full(stat_full)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_half();
        return q.size() >= DEPTH / 2;
    endfunction

    function automatic bit exp_full();
        return q.size() == DEPTH;
    endfunction

    // Bench model of one clock edge, from the requirements.
    task automatic model(input bit w, input logic [31:0] d, input bit r1, input bit ra);
        bit has, pop, fire, full;
        has = q.size() != 0;
        pop = 0; fire = 0;
        if (!m_drain) begin
            if (ra || r1) begin fire = 1; pop = has; end
        end else begin
            fire = has; pop = has;
        end
        e_valid = fire;
        e_word  = pop ? q[0] : 32'h0;
        full = (q.size() == DEPTH);
        if (pop) void'(q.pop_front());
        if (w) begin
            if (full && !pop) q[q.size() - 1] = d;
            else q.push_back(d);
        end
        if (!m_drain) m_drain = ra && has && (q.size() != 0);
        else          m_drain = (q.size() != 0);
    endtask

    task automatic compare(input string tag);
        check(rd_valid === e_valid, tag, "rd_valid", 32'(rd_valid), 32'(e_valid));
        check(rd_word === e_word, tag, "rd_word", rd_word, e_word);
        check(stat_half === exp_half(), "R4", "stat_half", 32'(stat_half), 32'(exp_half()));
        check(stat_full === exp_full(), "R5", "stat_full", 32'(stat_full), 32'(exp_full()));
        check(stat_empty === (q.size() == 0), "R10", "stat_empty",
              32'(stat_empty), 32'(q.size() == 0));
        check(data_ready === (q.size() != 0), "R2", "data_ready",
              32'(data_ready), 32'(q.size() != 0));
    endtask

    task automatic step(input bit w, input logic [31:0] d, input bit r1, input bit ra,
                        input string tag);
        wr_stb = w; wr_word = d; rd_one = r1; rd_all = ra;
        model(w, d, r1, ra);
        @(posedge clk);
        @(negedge clk);
        wr_stb = 0; rd_one = 0; rd_all = 0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1; wr_stb = 0; rd_one = 0; rd_all = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        q.delete(); m_drain = 0;
        check(stat_empty === 1'b1, "R1", "stat_empty", 32'(stat_empty), 32'h1);
        check(data_ready === 1'b0, "R1", "data_ready", 32'(data_ready), 32'h0);
        check(stat_half === 1'b0, "R1", "stat_half", 32'(stat_half), 32'h0);
        check(stat_full === 1'b0, "R1", "stat_full", 32'(stat_full), 32'h0);
        check(rd_valid === 1'b0, "R1", "rd_valid", 32'(rd_valid), 32'h0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0429));
        do_reset();

        // R2 / R7 / R11: small traffic
        step(1, 32'hA0A0_0001, 0, 0, "R2");
        step(1, 32'hA0A0_0002, 0, 0, "R2");
        step(1, 32'hA0A0_0003, 0, 0, "R2");
        step(0, 32'h0, 1, 0, "R7");
        step(1, 32'hA0A0_0004, 1, 0, "R11");
        check(q.size() == 2, "R11", "model size", 32'(q.size()), 32'd2);

        // R4 / R5: fill to exactly 32
        while (q.size() < DEPTH) step(1, $urandom, 0, 0, "R5");
        // R6: writes at full rewrite the newest slot
        step(1, 32'hDEAD_0001, 0, 0, "R6");
        step(1, 32'hDEAD_0002, 0, 0, "R6");
        // R11 at full: pop oldest, append new
        step(1, 32'hC0DE_0001, 1, 0, "R11");
        check(q.size() == DEPTH, "R11", "model size", 32'(q.size()), 32'(DEPTH));

        // R8: drain with ignored commands interleaved
        step(0, 32'h0, 0, 1, "R8");
        for (int i = 0; m_drain && i < 64; i++) step(0, 32'h0, i % 2 == 0, i % 3 == 0, "R8");
        check(q.size() == 0, "R8", "model size", 32'(q.size()), 32'd0);

        // R9: reads on an empty store
        step(0, 32'h0, 1, 0, "R9");
        step(0, 32'h0, 0, 1, "R9");
        step(0, 32'h0, 0, 0, "R9");

        // R8: drain fed by writes during the drain
        step(1, 32'hB0B0_0001, 0, 0, "R8");
        step(1, 32'hB0B0_0002, 0, 1, "R8");
        step(1, 32'hB0B0_0003, 0, 0, "R8");
        for (int i = 0; m_drain && i < 8; i++) step(0, 32'h0, 0, 0, "R8");

        // R1: reset with content held
        for (int i = 0; i < 5; i++) step(1, $urandom, 0, 0, "R3");
        do_reset();

        // R3: random traffic
        for (int i = 0; i < 3000; i++) begin
            bit w, r1, ra;
            w  = ($urandom % 8) < 5;
            r1 = ($urandom % 4) == 0;
            ra = ($urandom % 40) == 0;
            step(w, $urandom, r1, ra, "R3");
        end
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule